// File: doc/BRIEF.md
# Dual-Select Static RAM Array

This block is a small word-addressed static RAM of 128 bytes with a 7-bit address. Two select inputs gate every access: one active high and one active low. The part is live only when both selects are in their active state. Separate read and write strobes choose the operation. Reads are combinational from the address. Writes land on the rising clock edge.

The data bus is split into a data-in byte, a data-out byte and an output-enable flag, so the block stays synthesizable. Output enable low stands for a released, high-impedance bus. A top level that needs a real shared bus can place a tri-state buffer on `dataOut`, controlled by `outEn`. A read strobe always overrides a write strobe. While reset is held, the bus is released and stores are blocked. The array contents are not initialised.

Top module: `dual_sel_ram`

## Requirements
- R1: The array holds 128 independent 8-bit words addressed by `addr[6:0]`; each location returns the last byte stored to it.
- R2: The block is enabled only when `sel1` is 1 and `sel2N` is 0; outside that pair `outEn` stays 0 whatever the strobes do.
- R3: With the block not enabled, a write strobe leaves every location unchanged.
- R4: Enabled with `rdStb`=0 and `wrStb`=0, `outEn` is 0 and no location changes.
- R5: Enabled with `rdStb`=0 and `wrStb`=1, `dataIn` is stored at `addr` on the rising clock edge and is readable from the following cycle.
- R6: Enabled with `rdStb`=1, `outEn` is 1 and `dataOut` equals the addressed byte in the same cycle, following address changes without a clock edge.
- R7: Enabled with `rdStb`=1 and `wrStb`=1 at the same time, the read is performed and no store occurs.
- R8: Whenever `outEn` is 0, `dataOut` is 0.
- R9: While `rstN` is 0, `outEn` is 0 and writes are blocked; the array keeps its contents across a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores occur on its rising edge |
| rstN | input | 1 | Active-low reset; releases the bus and blocks stores |
| sel1 | input | 1 | Active-high select |
| sel2N | input | 1 | Active-low select |
| rdStb | input | 1 | Read strobe, active high, wins over a write |
| wrStb | input | 1 | Write strobe, active high |
| addr | input | 7 | Word address |
| dataIn | input | 8 | Byte to store |
| dataOut | output | 8 | Addressed byte while reading, else 0 |
| outEn | output | 1 | Output enable; 0 means the bus is released |

## Verification
A decode fault in the select or strobe logic shows at once at the ports. Either `outEn` rises in a combination that must keep the bus released, or it stays low during a valid read, in the same cycle as the stimulus. A wrong store, whether it is missing, misdirected, or slips through while inhibited or during a read, is hidden until that location is read again. For that reason the bench reads back the touched address in the very next cycle. It also sweeps the whole array against a reference copy, so corruption of a neighbouring location is found within one full pass.

// File: rtl/dual_sel_ram_pkg.sv
package dual_sel_ram_pkg;

  // Strobes from the decode logic to the storage datapath
  typedef struct packed {
    logic chipEn;
    logic rdEn;
    logic wrEn;
  } ramStrobes_t;

endpackage

// File: rtl/dual_sel_ram_ctrl.sv
module dual_sel_ram_ctrl
  import dual_sel_ram_pkg::*;
(
  input  logic        rstN,
  input  logic        sel1,
  input  logic        sel2N,
  input  logic        rdStb,
  input  logic        wrStb,
  output ramStrobes_t strobes
);

  logic selMatch;

  // Both selects must sit in their active state at the same time
  assign selMatch = sel1 & ~sel2N;

  always_comb begin
    strobes.chipEn = selMatch & rstN;
    // Read has priority: a write is only honoured with the read strobe low
    strobes.rdEn   = strobes.chipEn & rdStb;
    strobes.wrEn   = strobes.chipEn & ~rdStb & wrStb;
  end

endmodule

// File: rtl/dual_sel_ram_dpath.sv
module dual_sel_ram_dpath
  import dual_sel_ram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  ramStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      memArray[addr] <= dataIn;
    end
  end

  // Released bus is modelled as enable low with a quiet data word
  always_comb begin
    outEn   = strobes.rdEn;
    dataOut = strobes.rdEn ? memArray[addr] : '0;
  end

endmodule

// File: rtl/dual_sel_ram.sv
module dual_sel_ram
  import dual_sel_ram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel1,
  input  logic              sel2N,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outEn
);

  ramStrobes_t strobes;

  dual_sel_ram_ctrl u_ctrl (
    .rstN    (rstN),
    .sel1    (sel1),
    .sel2N   (sel2N),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .strobes (strobes)
  );

  dual_sel_ram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk     (clk),
    .strobes (strobes),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .outEn   (outEn)
  );

endmodule

// File: rtl/dual_sel_ram_chk.sv
module dual_sel_ram_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sel1,
  input logic              sel2N,
  input logic              rdStb,
  input logic              wrStb,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              outEn
);

  logic live;
  assign live = sel1 && !sel2N;

  AST_EN_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> (sel1 && !sel2N)); // R2

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (live && !rdStb) |-> !outEn); // R4

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (live && rdStb) |-> outEn); // R6

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (dataOut == '0)); // R8

  AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (live && rdStb && $past(rstN) && $past(live) && !$past(rdStb)
     && $past(wrStb) && $stable(addr))
    |-> (dataOut == $past(dataIn))); // R5

  AST_READ_BLOCKS_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (live && rdStb && $past(rstN) && $past(live) && $past(rdStb)
     && $stable(addr))
    |-> $stable(dataOut)); // R7

endmodule

bind dual_sel_ram dual_sel_ram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sel1    (sel1),
  .sel2N   (sel2N),
  .rdStb   (rdStb),
  .wrStb   (wrStb),
  .addr    (addr),
  .dataIn  (dataIn),
  .dataOut (dataOut),
  .outEn   (outEn)
);

// File: tb/dual_sel_ram_test.sv
module dual_sel_ram_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 1 << ADDR_W;

  // Vector: {sel1, sel2N, rdStb, wrStb, addr[6:0], data[7:0]}
  localparam logic [18:0] VECS [16] = '{
    {4'b0000, 7'd3,   8'h11}, {4'b0001, 7'd4,   8'h22},
    {4'b0010, 7'd5,   8'h33}, {4'b0011, 7'd6,   8'h44},
    {4'b0100, 7'd7,   8'h55}, {4'b0101, 7'd8,   8'h66},
    {4'b0110, 7'd9,   8'h77}, {4'b0111, 7'd10,  8'h88},
    {4'b1000, 7'd11,  8'h99}, {4'b1001, 7'd12,  8'hAA},
    {4'b1010, 7'd13,  8'hBB}, {4'b1011, 7'd14,  8'hCC},
    {4'b1100, 7'd15,  8'hDD}, {4'b1101, 7'd16,  8'hEE},
    {4'b1110, 7'd17,  8'hF1}, {4'b1111, 7'd127, 8'hF2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sel1 = 1'b0;
  logic              sel2N = 1'b1;
  logic              rdStb = 1'b0;
  logic              wrStb = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              outEn;

  logic [DATA_W-1:0] refMem [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_sel_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .sel1(sel1), .sel2N(sel2N),
    .rdStb(rdStb), .wrStb(wrStb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .outEn(outEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Inputs change just after a rising edge; results are sampled mid-cycle
  task automatic drive(input bit s1, input bit s2n, input bit rd, input bit wr,
                       input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk); #1;
    sel1 = s1; sel2N = s2n; rdStb = rd; wrStb = wr; addr = a; dataIn = d;
    #(CLK_PERIOD/2 - 1);
  endtask

  task automatic readBack(input logic [ADDR_W-1:0] a, input string req);
    drive(1, 0, 1, 0, a, 8'h00);
    check(outEn == 1'b1, req, outEn, 1);
    check(dataOut == refMem[a], req, dataOut, refMem[a]);
  endtask

  initial begin
    // R9: held in reset with a live read request, bus stays released
    sel1 = 1; sel2N = 0; rdStb = 1; addr = 7'd0;
    #(CLK_PERIOD*2 + 2);
    check(outEn == 1'b0, "R9", outEn, 0);
    check(dataOut == '0, "R8", dataOut, 0);
    rdStb = 0;
    @(posedge clk); #1; rstN = 1;

    // R1: fill the whole array, then sweep it back
    for (int i = 0; i < DEPTH; i++) begin
      refMem[i] = 8'(i * 37 + 5);
      drive(1, 0, 0, 1, 7'(i), refMem[i]);
    end
    for (int i = 0; i < DEPTH; i++) readBack(7'(i), "R1");

    // Table walk over every select and strobe combination
    for (int v = 0; v < 16; v++) begin
      logic s1, s2n, rd, wr, en;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      string tag;
      {s1, s2n, rd, wr, a, d} = VECS[v];
      en = s1 && !s2n;
      tag = !en ? "R3" : rd ? (wr ? "R7" : "R6") : (wr ? "R5" : "R4");
      drive(s1, s2n, rd, wr, a, d);
      check(outEn == (en && rd), en ? tag : "R2", outEn, en && rd);
      check(dataOut == ((en && rd) ? refMem[a] : 8'h00), "R8", dataOut,
            (en && rd) ? refMem[a] : 8'h00);
      if (en && !rd && wr) refMem[a] = d;
      readBack(a, tag);
    end

    // R6: data follows the address with no clock edge
    drive(1, 0, 1, 0, 7'd20, 8'h00);
    check(dataOut == refMem[20], "R6", dataOut, refMem[20]);
    addr = 7'd21; #1;
    check(dataOut == refMem[21], "R6", dataOut, refMem[21]);

    // R5: back-to-back stores at both ends of the address space
    drive(1, 0, 0, 1, 7'd0, 8'h5A); refMem[0] = 8'h5A;
    drive(1, 0, 0, 1, 7'd127, 8'hA5); refMem[127] = 8'hA5;
    readBack(7'd0, "R5");
    readBack(7'd127, "R5");

    // R9: store attempted during reset is blocked, contents survive
    @(posedge clk); #1; rstN = 0;
    drive(1, 0, 0, 1, 7'd30, ~refMem[30]);
    drive(1, 0, 1, 0, 7'd30, 8'h00);
    check(outEn == 1'b0, "R9", outEn, 0);
    @(posedge clk); #1; rstN = 1;
    readBack(7'd30, "R9");

    // R1: final full sweep catches any stray store
    for (int i = 0; i < DEPTH; i++) readBack(7'(i), "R1");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  end

endmodule